// File: doc/BRIEF.md
# Event Input Conditioner

This block prepares an external event line for a timer that counts events. It brings the raw pin into the system clock domain and can optionally filter it with a noise rejector. It then turns every accepted transition of the selected direction into a one-cycle count pulse for the downstream counter.

The rejector is timed by a slow internal strobe of nominally 2048 Hz. The strobe is a level signal that is already synchronous to the system clock. A level that differs from the last accepted level is taken over only at the second falling edge of the strobe that occurs while the difference persists. A pulse that spans two strobe periods is therefore always counted. A glitch no longer than one strobe period is never counted.

The polarity select and the rejector enable act only while the event-count mode input is high. Both are expected to be 0 after reset.

Top module: `event_conditioner`

## Requirements
- R1: The pin passes through a two-flop synchroniser. With the rejector bypassed, a level change on the pin that is set up before a clock edge makes `pulse_o` high in the third clock cycle after that edge.
- R2: `edge_sel_i` = 1 counts low-to-high transitions and `edge_sel_i` = 0 counts high-to-low transitions of the conditioned level.
- R3: With `filt_en_i` = 0 the rejector is bypassed, and any pin level held for at least one clock cycle yields one count pulse.
- R4: With `filt_en_i` = 1 the accepted level changes only on the clock edge that follows a 1-to-0 transition of `strobe_i`. The number of strobe falls tallied per pending change never exceeds one.
- R5: With the rejector on, a new level that is held for more than two strobe periods is accepted and gives exactly one count pulse, whatever the strobe phase.
- R6: With the rejector on, a pulse no longer than one strobe period gives no count pulse, whatever the strobe phase.
- R7: If the synchronised level returns to the accepted level before the second strobe fall, the tally clears. Two short glitches separated by one clock cycle are therefore rejected.
- R8: Every count pulse is exactly one clock cycle wide.
- R9: While `cnt_mode_i` is 0, `pulse_o` stays 0 whatever the pin, polarity and rejector inputs do.
- R10: During and after reset `pulse_o` is 0. The accepted level resets low, so leaving reset with the pin low produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw external event line |
| strobe_i | input | 1 | Slow rejector timing strobe, synchronous to clk_i |
| edge_sel_i | input | 1 | 1: count rising edges, 0: count falling edges |
| filt_en_i | input | 1 | 1: route through noise rejector, 0: bypass |
| cnt_mode_i | input | 1 | Event-count mode enable |
| pulse_o | output | 1 | One-cycle count pulse |

## Verification
The hardest case to reach is a pending level change whose tally has already advanced once and then must be cleared. That requires two short glitches, each of which straddles exactly one strobe fall. The bench aligns itself to a strobe it generates, then sweeps every phase offset of a glitch pair and of single pulses of various widths. Phases where a missing clear would let a change through are therefore always covered. The bench computes the expected counts from the strobe period alone.

// File: rtl/ec_pkg.sv
package ec_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned REJ_EDGES_DEF   = 2;
endpackage

// File: rtl/ec_sync.sv
module ec_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ec_rejector.sv
module ec_rejector #(
  parameter int unsigned REJ_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  input  logic strobe_i,
  output logic lvl_o
);
  localparam int unsigned TALLY_W = $clog2(REJ_EDGES + 1);
  localparam logic [TALLY_W-1:0] LAST = TALLY_W'(REJ_EDGES - 1);

  logic               acc_q;
  logic               stb_q;
  logic [TALLY_W-1:0] tally_q;
  logic               stb_fall;

  assign stb_fall = stb_q & ~strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= 1'b0;
      stb_q   <= 1'b0;
      tally_q <= '0;
    end else begin
      stb_q <= strobe_i;
      if (!en_i) begin
        // track input so enabling the filter makes no edge
        acc_q   <= lvl_i;
        tally_q <= '0;
      end else if (lvl_i == acc_q) begin
        tally_q <= '0;
      end else if (stb_fall) begin
        if (tally_q == LAST) begin
          acc_q   <= lvl_i;
          tally_q <= '0;
        end else begin
          tally_q <= tally_q + 1'b1;
        end
      end
    end
  end

  assign lvl_o = acc_q;
endmodule

// File: rtl/ec_edge.sv
module ec_edge
  import ec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic edge_sel_i,
  input  logic mode_i,
  output logic pulse_o
);
  logic  lvl_q;
  logic  pulse_q;
  logic  hit;
  edge_e sel;

  assign sel = edge_e'(edge_sel_i);

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = lvl_i & ~lvl_q;
      default:   hit = ~lvl_i & lvl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_i;
      pulse_q <= mode_i & hit;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/event_conditioner.sv
module event_conditioner
  import ec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned REJ_EDGES   = REJ_EDGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic strobe_i,
  input  logic edge_sel_i,
  input  logic filt_en_i,
  input  logic cnt_mode_i,
  output logic pulse_o
);
  logic sync_lvl;
  logic acc_lvl;
  logic cond_lvl;
  logic filt_on;
  logic rise_sel;

  // controls only matter in event-count mode
  assign filt_on  = cnt_mode_i & filt_en_i;
  assign rise_sel = cnt_mode_i & edge_sel_i;

  ec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_lvl)
  );

  ec_rejector #(.REJ_EDGES(REJ_EDGES)) u_rej (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (filt_on),
    .lvl_i    (sync_lvl),
    .strobe_i (strobe_i),
    .lvl_o    (acc_lvl)
  );

  assign cond_lvl = filt_on ? acc_lvl : sync_lvl;

  ec_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (cond_lvl),
    .edge_sel_i (rise_sel),
    .mode_i     (cnt_mode_i),
    .pulse_o    (pulse_o)
  );
endmodule

// File: rtl/ec_checker.sv
module ec_checker #(
  parameter int unsigned TALLY_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               strobe_i,
  input logic               filt_en_i,
  input logic               cnt_mode_i,
  input logic               pulse_o,
  input logic               acc_lvl,
  input logic               sync_lvl,
  input logic [TALLY_W-1:0] tally
);
  always_comb
    if (!rst_ni) a_r10_reset_quiet: assert (pulse_o == 1'b0);

  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  a_r9_mode_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_mode_i |=> !pulse_o);

  a_r4_accept_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(filt_en_i && cnt_mode_i) && $past(acc_lvl) != acc_lvl)
      |-> ($past(strobe_i, 2) && !$past(strobe_i)));

  a_r4_tally_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tally <= TALLY_W'(1));

  a_r7_tally_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_lvl == acc_lvl) |=> (tally == '0));
endmodule

bind event_conditioner ec_checker #(.TALLY_W($clog2(REJ_EDGES + 1))) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_i   (strobe_i),
  .filt_en_i  (filt_en_i),
  .cnt_mode_i (cnt_mode_i),
  .pulse_o    (pulse_o),
  .acc_lvl    (acc_lvl),
  .sync_lvl   (sync_lvl),
  .tally      (u_rej.tally_q)
);

// File: tb/event_conditioner_bench.sv
module event_conditioner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 8;   // strobe period in clocks
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pin = 1'b0, strobe = 1'b0, edge_sel = 1'b0, filt_en = 1'b0, cnt_mode = 1'b0;
  logic pulse;

  int checks = 0, fails = 0, pulses = 0, wide = 0, ph = 0;
  logic pulse_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_conditioner u_event_conditioner (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .strobe_i(strobe),
    .edge_sel_i(edge_sel), .filt_en_i(filt_en), .cnt_mode_i(cnt_mode),
    .pulse_o(pulse)
  );

  // strobe generator and pulse monitor, all at negedge
  always @(negedge clk) begin
    ph     <= (ph + 1) % P;
    strobe <= ((ph + 1) % P) < P/2;
    if (pulse) pulses <= pulses + 1;
    if (pulse && pulse_prev) wide <= wide + 1;
    pulse_prev <= pulse;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic align(input int k);
    @(negedge clk);
    while (ph != 0) @(negedge clk);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_pin(input int w);
    pin = 1'b1;
    repeat (w) @(negedge clk);
    pin = 1'b0;
  endtask

  int base;

  initial begin
    cyc(3);
    check("R10 reset pulse", pulse, 0);
    rst_ni = 1'b1;
    cnt_mode = 1'b1;
    cyc(6);
    check("R10 no edge out of reset", pulses, 0);

    // R1 latency, bypass, rising
    edge_sel = 1'b1;
    @(negedge clk); pin = 1'b1;
    cyc(2); check("R1 not before third cycle", pulse, 0);
    cyc(1); check("R1 pulse at third cycle", pulse, 1);
    cyc(1); check("R8 pulse one cycle", pulse, 0);
    pin = 1'b0; cyc(6);

    // R2 polarity, both filter modes
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 2; s++) begin
        filt_en = f[0]; edge_sel = s[0];
        cyc(4 * P);
        base = pulses;
        @(negedge clk); pin = 1'b1;
        cyc(3 * P + 6);
        check("R2 count after rise", pulses - base, s);
        pin = 1'b0;
        cyc(3 * P + 6);
        check("R2 count after fall", pulses - base, 1);
      end
    end

    // R3 bypass: short widths counted once
    filt_en = 1'b0;
    for (int s = 0; s < 2; s++) begin
      edge_sel = s[0];
      for (int w = 1; w <= 4; w++) begin
        cyc(6); base = pulses;
        @(negedge clk); pulse_pin(w);
        cyc(8);
        check("R3 bypass width", pulses - base, 1);
      end
    end

    // R6 reject: widths up to one strobe period, all phases
    filt_en = 1'b1; edge_sel = 1'b1;
    for (int w = 1; w <= P; w++) begin
      base = pulses;
      for (int k = 0; k < P; k++) begin
        align(k); pulse_pin(w); cyc(3 * P);
      end
      check("R6 glitch rejected", pulses - base, 0);
    end

    // R5 accept: widths over two strobe periods, all phases
    for (int s = 0; s < 2; s++) begin
      edge_sel = s[0];
      for (int w = 2 * P + 1; w <= 2 * P + 3; w++) begin
        base = pulses;
        for (int k = 0; k < P; k++) begin
          align(k); pulse_pin(w); cyc(4 * P);
        end
        check("R5 long pulse accepted", pulses - base, P);
      end
    end

    // R7 tally clear: two glitches separated by one low cycle
    edge_sel = 1'b1;
    base = pulses;
    for (int k = 0; k < P; k++) begin
      align(k);
      pulse_pin(P);
      @(negedge clk);
      pulse_pin(P);
      cyc(4 * P);
    end
    check("R7 split glitch rejected", pulses - base, 0);

    // R9 mode off: nothing counted
    cnt_mode = 1'b0;
    base = pulses;
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 2; s++) begin
        filt_en = f[0]; edge_sel = s[0];
        @(negedge clk); pulse_pin(3 * P);
        cyc(4 * P);
      end
    end
    check("R9 mode off silent", pulses - base, 0);

    check("R8 no wide pulses", wide, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule